// File: doc/BRIEF.md
# Relocatable On-Chip Block Address Decoder

This block sits on a processor bus with 24-bit byte addresses and 16-bit data and decides, for every access, whether the access targets on-chip resources. It owns a small window of configuration registers at a fixed low address and a programmable base register that places a 4K-byte internal region (user RAM, unimplemented space and further internal resources) on any 4K boundary. The region match can optionally also require the bus function code to equal a value held in the base register.

For each access the decoder raises an internal-access flag and exactly one region select. It also serves reads and writes of the base, system-control and clock-control registers directly. All decode outputs are combinational from the bus inputs. Register writes take effect at the rising clock edge of a cycle in which the write is presented. The base register survives a partial reset and is cleared only by the full system reset.

Top module: `ocb_decoder`

## Requirements
- R1: After a full system reset, reading byte address $0F2 returns $BFFF, $0F4 returns $0000, $0F6 returns $0F00 and $0FA returns $0000.
- R2: A partial reset (`rst_n` low, `rst_sys_n` high) returns the system-control register to $0000_0F00 and the clock-control register to $0000, and leaves the base register unchanged.
- R3: Any access with `bus_as` high to byte addresses $0F0–$0FF raises `sel_cfg` and `iac`, whatever the base register holds.
- R4: With base bit 12 clear, an access hits the 4K region when address bits 23:12 equal base bits 11:0, for any function code.
- R5: With base bit 12 set, a region hit also needs `bus_fc` equal to base bits 15:13. The reset base value $BFFF places the region at $FFF000 and requires function code 5.
- R6: Within a hit region, offset bits 11:0 below $240 raise `sel_ram`, $240–$3FF raise `sel_rsv`, and $400–$FFF raise `sel_per`. At most one select is high at a time.
- R7: `iac` is high exactly when a select is high. With `bus_as` low, or with an address outside both windows, all selects are low and `bus_rdata` is zero.
- R8: A write to a register changes only the bytes whose strobe is set: `bus_ub` for bits 15:8 and `bus_lb` for bits 7:0.
- R9: The 32-bit system-control register is written and read as two words: $0F4 holds bits 31:16 and $0F6 holds bits 15:0.
- R10: The reserved words $0F0, $0F8, $0FC and $0FE read as zero, and writes to them change no register.
- R11: When the programmed region overlaps $0F0–$0FF, the fixed window takes precedence there. The rest of the region still decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_sys_n | input | 1 | Full system reset, active low, synchronous; resets every register |
| rst_n | input | 1 | Partial reset, active low, synchronous; spares the base register |
| bus_as | input | 1 | Access valid (address strobe) |
| bus_addr | input | 24 | Byte address; bit 0 is ignored for word accesses |
| bus_fc | input | 3 | Bus function code |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ub | input | 1 | Upper byte strobe (data bits 15:8) |
| bus_lb | input | 1 | Lower byte strobe (data bits 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read data, zero when no register is read |
| iac | output | 1 | Internal access: some on-chip location is addressed |
| sel_cfg | output | 1 | Fixed configuration window selected |
| sel_ram | output | 1 | User RAM part of the region selected |
| sel_rsv | output | 1 | Unimplemented part of the region selected |
| sel_per | output | 1 | Remaining internal part of the region selected |

## Verification
The decode is exercised with the reset base, where the function code gates the hit, and then with a base that ignores the function code. Addresses are placed on both sides of every region limit ($23E/$240, $3FE/$400, $FFE and the next 4K page), so that an off-by-one in any compare shows up as a wrong select. A base that overlaps the fixed window checks the precedence between the two windows. Register traffic uses single-strobe writes, writes to reserved words, and the two halves of the 32-bit register. A partial reset is followed by a full reset, which shows which registers each reset reaches.

// File: rtl/ocb_pkg.sv
package ocb_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int BLK_AW = 12;               // 4K-byte region
  localparam int HI_W   = ADDR_W - BLK_AW;  // compared address bits

  // word slot inside the fixed window, indexed by address bits 3:1
  typedef enum logic [2:0] {
    SLOT_RSV0 = 3'd0, SLOT_BASE = 3'd1, SLOT_SCRH = 3'd2, SLOT_SCRL = 3'd3,
    SLOT_RSV1 = 3'd4, SLOT_CLK  = 3'd5, SLOT_RSV2 = 3'd6, SLOT_RSV3 = 3'd7
  } slot_e;

  // base register: [15:13] expected function code, [12] compare enable,
  // [11:0] region address bits 23:12
  function automatic logic region_match(input logic [HI_W-1:0] hi,
                                        input logic [DATA_W-1:0] base,
                                        input logic [2:0] fc);
    logic addr_ok, fc_ok;
    addr_ok = (hi == base[HI_W-1:0]);
    fc_ok   = !base[12] || (fc == base[15:13]);
    return addr_ok && fc_ok;
  endfunction

  // byte-strobe merge of a register word
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old,
                                                    input logic [DATA_W-1:0] nw,
                                                    input logic ub, input logic lb);
    return {ub ? nw[15:8] : old[15:8], lb ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic is_rsv_slot(input slot_e s);
    return (s == SLOT_RSV0) || (s == SLOT_RSV1) || (s == SLOT_RSV2) || (s == SLOT_RSV3);
  endfunction
endpackage

// File: rtl/ocb_fixed_decode.sv
module ocb_fixed_decode
  import ocb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIXED_BASE = 24'h0000F0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output slot_e             slot,
  output logic              rsv
);
  localparam int WIN_LSB = 4;   // 16-byte window

  assign hit  = (addr[ADDR_W-1:WIN_LSB] == FIXED_BASE[ADDR_W-1:WIN_LSB]);
  assign slot = slot_e'(addr[3:1]);
  assign rsv  = is_rsv_slot(slot);
endmodule

// File: rtl/ocb_block_match.sv
module ocb_block_match
  import ocb_pkg::*;
#(
  parameter int RAM_BYTES = 576,
  parameter int RSV_LIMIT = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  input  logic [DATA_W-1:0] base,
  output logic              hit,
  output logic              ram,
  output logic              rsv,
  output logic              per
);
  localparam logic [BLK_AW:0] RAM_LIM = (BLK_AW+1)'(RAM_BYTES);
  localparam logic [BLK_AW:0] RSV_LIM = (BLK_AW+1)'(RSV_LIMIT);

  logic [BLK_AW:0] off;

  assign off = {1'b0, addr[BLK_AW-1:0]};
  assign hit = region_match(addr[ADDR_W-1:BLK_AW], base, fc);
  assign ram = hit && (off < RAM_LIM);
  assign rsv = hit && (off >= RAM_LIM) && (off < RSV_LIM);
  assign per = hit && (off >= RSV_LIM);
endmodule

// File: rtl/ocb_cfg_regs.sv
module ocb_cfg_regs
  import ocb_pkg::*;
#(
  parameter logic [DATA_W-1:0]   BASE_RST = 16'hBFFF,
  parameter logic [2*DATA_W-1:0] SCR_RST  = 32'h0000_0F00,
  parameter logic [DATA_W-1:0]   CLK_RST  = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_sys_n,
  input  logic                rst_n,
  input  logic                wr_en,
  input  slot_e               slot,
  input  logic                ub,
  input  logic                lb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   base_q,
  output logic [2*DATA_W-1:0] scr_q,
  output logic [DATA_W-1:0]   ckcr_q,
  output logic [DATA_W-1:0]   rd_word
);
  logic part_rst;
  assign part_rst = !rst_sys_n || !rst_n;

  // base register: full system reset only
  always_ff @(posedge clk) begin
    if (!rst_sys_n)
      base_q <= BASE_RST;
    else if (wr_en && slot == SLOT_BASE)
      base_q <= merge_bytes(base_q, wdata, ub, lb);
  end

  always_ff @(posedge clk) begin
    if (part_rst) begin
      scr_q  <= SCR_RST;
      ckcr_q <= CLK_RST;
    end else if (wr_en) begin
      if (slot == SLOT_SCRH)
        scr_q[2*DATA_W-1:DATA_W] <= merge_bytes(scr_q[2*DATA_W-1:DATA_W], wdata, ub, lb);
      if (slot == SLOT_SCRL)
        scr_q[DATA_W-1:0] <= merge_bytes(scr_q[DATA_W-1:0], wdata, ub, lb);
      if (slot == SLOT_CLK)
        ckcr_q <= merge_bytes(ckcr_q, wdata, ub, lb);
    end
  end

  always_comb begin
    case (slot)
      SLOT_BASE: rd_word = base_q;
      SLOT_SCRH: rd_word = scr_q[2*DATA_W-1:DATA_W];
      SLOT_SCRL: rd_word = scr_q[DATA_W-1:0];
      SLOT_CLK:  rd_word = ckcr_q;
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/ocb_decoder.sv
module ocb_decoder
  import ocb_pkg::*;
#(
  parameter logic [ADDR_W-1:0]   FIXED_BASE = 24'h0000F0,
  parameter int                  RAM_BYTES  = 576,
  parameter int                  RSV_LIMIT  = 1024,
  parameter logic [DATA_W-1:0]   BASE_RST   = 16'hBFFF,
  parameter logic [2*DATA_W-1:0] SCR_RST    = 32'h0000_0F00,
  parameter logic [DATA_W-1:0]   CLK_RST    = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_sys_n,
  input  logic              rst_n,
  input  logic              bus_as,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_fc,
  input  logic              bus_we,
  input  logic              bus_ub,
  input  logic              bus_lb,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              iac,
  output logic              sel_cfg,
  output logic              sel_ram,
  output logic              sel_rsv,
  output logic              sel_per
);
  // named internal events for the checker
  logic                fix_hit, fix_rsv;
  slot_e               slot;
  logic                blk_hit, blk_ram, blk_rsv, blk_per;
  logic                blk_open;
  logic                wr_cfg, wr_base;
  logic [DATA_W-1:0]   base_q, ckcr_q, rd_word;
  logic [2*DATA_W-1:0] scr_q;

  ocb_fixed_decode #(.FIXED_BASE(FIXED_BASE)) u_fix (
    .addr(bus_addr), .hit(fix_hit), .slot(slot), .rsv(fix_rsv)
  );

  ocb_block_match #(.RAM_BYTES(RAM_BYTES), .RSV_LIMIT(RSV_LIMIT)) u_blk (
    .addr(bus_addr), .fc(bus_fc), .base(base_q),
    .hit(blk_hit), .ram(blk_ram), .rsv(blk_rsv), .per(blk_per)
  );

  ocb_cfg_regs #(.BASE_RST(BASE_RST), .SCR_RST(SCR_RST), .CLK_RST(CLK_RST)) u_regs (
    .clk(clk), .rst_sys_n(rst_sys_n), .rst_n(rst_n),
    .wr_en(wr_cfg), .slot(slot), .ub(bus_ub), .lb(bus_lb), .wdata(bus_wdata),
    .base_q(base_q), .scr_q(scr_q), .ckcr_q(ckcr_q), .rd_word(rd_word)
  );

  // fixed window has precedence over an overlapping region
  assign sel_cfg  = bus_as && fix_hit;
  assign blk_open = bus_as && !fix_hit;
  assign sel_ram  = blk_open && blk_ram;
  assign sel_rsv  = blk_open && blk_rsv;
  assign sel_per  = blk_open && blk_per;
  assign iac      = sel_cfg || sel_ram || sel_rsv || sel_per;

  assign wr_cfg    = sel_cfg && bus_we;
  assign wr_base   = wr_cfg && (slot == SLOT_BASE);
  assign bus_rdata = (sel_cfg && !bus_we) ? rd_word : '0;
endmodule

// File: rtl/ocb_decoder_chk.sv
module ocb_decoder_chk
  import ocb_pkg::*;
#(
  parameter logic [ADDR_W-1:0]   FIXED_BASE = 24'h0000F0,
  parameter logic [2*DATA_W-1:0] SCR_RST    = 32'h0000_0F00,
  parameter logic [DATA_W-1:0]   CLK_RST    = 16'h0000
) (
  input logic                clk,
  input logic                rst_sys_n,
  input logic                rst_n,
  input logic                bus_as,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [2:0]          bus_fc,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                iac,
  input logic                sel_cfg,
  input logic                sel_ram,
  input logic                sel_rsv,
  input logic                sel_per,
  input logic                fix_rsv,
  input logic                wr_base,
  input logic [DATA_W-1:0]   base_q,
  input logic [2*DATA_W-1:0] scr_q,
  input logic [DATA_W-1:0]   ckcr_q
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_sys_n)
    $onehot0({sel_cfg, sel_ram, sel_rsv, sel_per}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sys_n)
    !bus_as |-> (!iac && bus_rdata == '0));

  p_fixed_win_r3: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (bus_as && bus_addr[ADDR_W-1:4] == FIXED_BASE[ADDR_W-1:4]) |-> (sel_cfg && iac));

  p_fc_gate_r5: assert property (@(posedge clk) disable iff (!rst_sys_n)
    ((sel_ram || sel_rsv || sel_per) && base_q[12]) |-> (bus_fc == base_q[15:13]));

  p_rsv_read_r10: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (sel_cfg && !bus_we && fix_rsv) |-> (bus_rdata == '0));

  p_rsv_write_r10: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (sel_cfg && bus_we && fix_rsv && rst_n) |=> ($stable(scr_q) && $stable(ckcr_q) && $stable(base_q)));

  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (!rst_n && !wr_base) |=> $stable(base_q));

  p_part_reset_r2: assert property (@(posedge clk) disable iff (!rst_sys_n)
    !rst_n |=> (scr_q == SCR_RST && ckcr_q == CLK_RST));
endmodule

bind ocb_decoder ocb_decoder_chk #(
  .FIXED_BASE(FIXED_BASE), .SCR_RST(SCR_RST), .CLK_RST(CLK_RST)
) u_chk (
  .clk(clk), .rst_sys_n(rst_sys_n), .rst_n(rst_n), .bus_as(bus_as),
  .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .iac(iac), .sel_cfg(sel_cfg), .sel_ram(sel_ram), .sel_rsv(sel_rsv), .sel_per(sel_per),
  .fix_rsv(fix_rsv), .wr_base(wr_base), .base_q(base_q), .scr_q(scr_q), .ckcr_q(ckcr_q)
);

// File: tb/ocb_decoder_bench.sv
module ocb_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_sys_n = 1'b0, rst_n = 1'b0;
  logic        bus_as = 1'b0, bus_we = 1'b0, bus_ub = 1'b0, bus_lb = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [2:0]  bus_fc = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        iac, sel_cfg, sel_ram, sel_rsv, sel_per;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // bench register model
  logic [15:0] bar_m = 16'hBFFF, ckcr_m = 16'h0;
  logic [31:0] scr_m = 32'h0000_0F00;

  typedef struct {
    logic [15:0] rd;
    logic [3:0]  sel;   // {cfg, ram, rsv, per}
    int          req;
    logic [23:0] addr;
  } item_t;
  item_t q[$];

  ocb_decoder u_ocb_decoder (
    .clk(clk), .rst_sys_n(rst_sys_n), .rst_n(rst_n), .bus_as(bus_as),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_we(bus_we), .bus_ub(bus_ub),
    .bus_lb(bus_lb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iac(iac),
    .sel_cfg(sel_cfg), .sel_ram(sel_ram), .sel_rsv(sel_rsv), .sel_per(sel_per)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] exp_sel(input logic [23:0] a, input logic [2:0] fc,
                                         input logic as, input logic [15:0] bar);
    logic [11:0] off;
    if (!as) return 4'b0000;
    if (a >= 24'h0000F0 && a <= 24'h0000FF) return 4'b1000;
    if (a[23:12] != bar[11:0]) return 4'b0000;
    if (bar[12] && fc != bar[15:13]) return 4'b0000;
    off = a[11:0];
    if (off < 12'h240) return 4'b0100;
    if (off < 12'h400) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [15:0] model_rd(input logic [23:0] a);
    case ({a[7:1], 1'b0})
      8'hF2:   return bar_m;
      8'hF4:   return scr_m[31:16];
      8'hF6:   return scr_m[15:0];
      8'hFA:   return ckcr_m;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                      input logic ub, input logic lb);
    return {ub ? n[15:8] : o[15:8], lb ? n[7:0] : o[7:0]};
  endfunction

  // driver: present one access, push the expected result, update the model
  task automatic access(input logic [23:0] a, input logic [2:0] fc, input logic as,
                        input logic we, input logic ub, input logic lb,
                        input logic [15:0] wd, input int req);
    item_t it;
    logic [3:0] s;
    @(negedge clk);
    bus_addr = a; bus_fc = fc; bus_as = as; bus_we = we;
    bus_ub = ub; bus_lb = lb; bus_wdata = wd;
    s = exp_sel(a, fc, as, bar_m);
    it.sel = s; it.req = req; it.addr = a;
    it.rd = (s[3] && !we) ? model_rd(a) : 16'h0;
    q.push_back(it);
    if (s[3] && we) begin
      case ({a[7:1], 1'b0})
        8'hF2: bar_m = mrg(bar_m, wd, ub, lb);
        8'hF4: scr_m[31:16] = mrg(scr_m[31:16], wd, ub, lb);
        8'hF6: scr_m[15:0] = mrg(scr_m[15:0], wd, ub, lb);
        8'hFA: ckcr_m = mrg(ckcr_m, wd, ub, lb);
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [23:0] a, input logic [2:0] fc, input int req);
    access(a, fc, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, req);
  endtask

  task automatic wr(input logic [23:0] a, input logic ub, input logic lb,
                    input logic [15:0] d, input int req);
    access(a, 3'd5, 1'b1, 1'b1, ub, lb, d, req);
  endtask

  task automatic do_reset(input bit full);
    @(negedge clk);
    bus_as = 1'b0; bus_we = 1'b0;
    if (full) rst_sys_n = 1'b0; else rst_n = 1'b0;
    @(negedge clk);
    rst_sys_n = 1'b1; rst_n = 1'b1;
    if (full) bar_m = 16'hBFFF;
    scr_m = 32'h0000_0F00; ckcr_m = 16'h0;
  endtask

  // monitor: compare between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [3:0] got;
        it = q.pop_front();
        got = {sel_cfg, sel_ram, sel_rsv, sel_per};
        checks++;
        if (got !== it.sel || bus_rdata !== it.rd || iac !== (|it.sel)) begin
          errors++;
          $display("FAIL R%0d addr=%h: sel=%b rdata=%h iac=%b expected sel=%b rdata=%h iac=%b",
                   it.req, it.addr, got, bus_rdata, iac, it.sel, it.rd, |it.sel);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R1: reset values
    rd(24'h0000F2, 3'd0, 1);
    rd(24'h0000F4, 3'd0, 1);
    rd(24'h0000F6, 3'd0, 1);
    rd(24'h0000FA, 3'd0, 1);
    // R5: reset base, region at FFF000 gated by fc 5
    rd(24'hFFF010, 3'd5, 5);
    rd(24'hFFF010, 3'd1, 5);
    // R4: base 0x0123, fc ignored
    wr(24'h0000F2, 1'b1, 1'b1, 16'h0123, 4);
    rd(24'h123010, 3'd2, 4);
    rd(24'h123010, 3'd7, 4);
    // R6: region limits
    rd(24'h12323E, 3'd0, 6);
    rd(24'h123240, 3'd0, 6);
    rd(24'h1233FE, 3'd0, 6);
    rd(24'h123400, 3'd0, 6);
    rd(24'h123FFE, 3'd0, 6);
    // R7: outside and idle
    rd(24'h124000, 3'd0, 7);
    rd(24'h122FFE, 3'd0, 7);
    access(24'h123010, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 7);
    // R3: fixed window regardless of base
    rd(24'h0000F0, 3'd3, 3);
    rd(24'h0000FF, 3'd6, 3);
    // R8: byte strobes
    wr(24'h0000FA, 1'b1, 1'b0, 16'hABCD, 8);
    rd(24'h0000FA, 3'd0, 8);
    wr(24'h0000FA, 1'b0, 1'b1, 16'h1234, 8);
    rd(24'h0000FA, 3'd0, 8);
    // R9: halves of the 32-bit register
    wr(24'h0000F4, 1'b1, 1'b1, 16'h1357, 9);
    wr(24'h0000F6, 1'b1, 1'b1, 16'h9BDF, 9);
    rd(24'h0000F4, 3'd0, 9);
    rd(24'h0000F6, 3'd0, 9);
    // R10: reserved words
    wr(24'h0000F0, 1'b1, 1'b1, 16'hFFFF, 10);
    wr(24'h0000F8, 1'b1, 1'b1, 16'hFFFF, 10);
    wr(24'h0000FC, 1'b1, 1'b1, 16'hFFFF, 10);
    wr(24'h0000FE, 1'b1, 1'b1, 16'hFFFF, 10);
    rd(24'h0000F0, 3'd0, 10);
    rd(24'h0000F8, 3'd0, 10);
    rd(24'h0000FE, 3'd0, 10);
    rd(24'h0000F2, 3'd0, 10);
    rd(24'h0000F6, 3'd0, 10);
    rd(24'h0000FA, 3'd0, 10);
    // R5: compare enabled with fc 2 at base 0x456
    wr(24'h0000F2, 1'b1, 1'b1, 16'h5456, 5);
    rd(24'h456100, 3'd2, 5);
    rd(24'h456100, 3'd3, 5);
    rd(24'h456500, 3'd2, 5);
    // R11: region at 0 overlapping fixed window
    wr(24'h0000F2, 1'b1, 1'b1, 16'h0000, 11);
    rd(24'h0000F2, 3'd0, 11);
    rd(24'h0000EE, 3'd0, 11);
    rd(24'h000100, 3'd0, 11);
    // R2: partial reset spares base
    wr(24'h0000F2, 1'b1, 1'b1, 16'h0777, 2);
    do_reset(1'b0);
    rd(24'h0000F2, 3'd0, 2);
    rd(24'h0000F4, 3'd0, 2);
    rd(24'h0000F6, 3'd0, 2);
    rd(24'h0000FA, 3'd0, 2);
    rd(24'h777200, 3'd0, 2);
    // R1: full reset restores base
    do_reset(1'b1);
    rd(24'h0000F2, 3'd0, 1);
    rd(24'hFFF250, 3'd5, 1);
    @(negedge clk);
    bus_as = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule